// File: doc/BRIEF.md
# Bus Snooping Trace Logger

This block sits beside a shared system bus as a silent observer. It never drives the bus. On every completed handshake it forms a trace record holding four things: the address, the data word, the transfer direction, and the program counter of the load or store that started the transfer. The program counter arrives on a side input that is valid together with the bus request. For a write the data word is taken from the master's write data. For a read it is taken from the slave's return data.

A filter register pair can be written from outside at run time. It holds an address mask and a match value, and it decides which records are kept. Writes to the reserved text-message address are always kept, so characters printed by software reach the trace whatever the filter says. Kept records go into a first-in first-out trace buffer. Once the buffer holds more than half its capacity, the block raises a drain request so that a packet builder reads the entries out. The request stays up until the entries present when it was raised have been read.

When the buffer is full, new records are lost and a drop counter counts them. At the start of the next drain request that counter is copied to a header output and restarted.

Top module: `bus_trace_logger`

## Requirements
- R1: A record is taken only on a rising clock edge where cycle, strobe and acknowledge are all high. It stores the side-input program counter, the address and the direction flag (1 = write). It stores the write data for a write and the read data for a read.
- R2: A transfer is kept when (address AND mask) equals (match AND mask). After reset, mask and match are both zero, so every transfer is kept. A pulse on the configuration strobe loads new mask and match values.
- R3: A write to address 0xFFFFFFFC is kept whatever the filter says. A read from that address is filtered like any other transfer.
- R4: Records leave the read port in the order they were kept. The read-valid output is high while the buffer is non-empty. A read strobe while valid removes the head entry. With no capture and no read, the fill level holds.
- R5: The drain request rises at the first clock edge at which the fill level is already above DEPTH/2 (at least 33 with the default depth of 64).
- R6: Once raised, the drain request stays high until as many entries have been read as the buffer held when it rose. It falls on the edge of that last read. Records added during the drain do not extend it.
- R7: A kept record that arrives while the buffer holds DEPTH entries is discarded, and the drop counter increments, saturating at its maximum. When a drain request rises, the drop count is copied to the header output and the counter restarts.
- R8: A read strobe while the buffer is empty has no effect. The fill level stays zero and the next kept record becomes the head.
- R9: After reset the fill level, read-valid, drain request and header drop count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_cyc | input | 1 | Bus cycle |
| wb_stb | input | 1 | Bus strobe |
| wb_ack | input | 1 | Bus acknowledge |
| wb_we | input | 1 | Bus write enable |
| wb_adr | input | 32 | Bus address |
| wb_dat_w | input | 32 | Master write data |
| wb_dat_r | input | 32 | Slave read data |
| pc_in | input | 32 | Program counter of the originating access |
| cfg_wr | input | 1 | Load mask and match |
| cfg_mask | input | 32 | Address mask to load |
| cfg_match | input | 32 | Address match value to load |
| rd_en | input | 1 | Pop head entry |
| rd_valid | output | 1 | Buffer non-empty |
| rd_pc | output | 32 | Head entry program counter |
| rd_addr | output | 32 | Head entry address |
| rd_data | output | 32 | Head entry data |
| rd_we | output | 1 | Head entry direction |
| fill | output | 7 | Entries held |
| flush_req | output | 1 | Drain request |
| hdr_drops | output | 8 | Drop count reported with the current packet |

## Verification
Handshakes that lack acknowledge or cycle are mixed with complete reads and writes. This shows whether capture depends on all three handshake signals and whether the correct data bus is sampled for each direction. Under a narrow filter, the bench sends a matching address, a non-matching address, and text-address writes and reads. These separate the filter compare from the text-address bypass and show that the bypass applies to writes only. The buffer is filled exactly past half, then topped up while draining, then overfilled. This shows when the drain request starts, that late records do not lengthen it, and which records are lost and how they are counted in the following header.

// File: rtl/bus_trace_logger.sv
module bus_trace_logger #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEPTH = 64,
  parameter int DCW = 8,
  parameter logic [AW-1:0] TEXT_ADDR = 32'hFFFF_FFFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_cyc,
  input  logic          wb_stb,
  input  logic          wb_ack,
  input  logic          wb_we,
  input  logic [AW-1:0] wb_adr,
  input  logic [DW-1:0] wb_dat_w,
  input  logic [DW-1:0] wb_dat_r,
  input  logic [AW-1:0] pc_in,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_mask,
  input  logic [AW-1:0] cfg_match,
  input  logic          rd_en,
  output logic          rd_valid,
  output logic [AW-1:0] rd_pc,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_we,
  output logic [$clog2(DEPTH):0] fill,
  output logic          flush_req,
  output logic [DCW-1:0] hdr_drops
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] FULL_LVL = (PW+1)'(DEPTH);
  localparam logic [PW:0] HALF_LVL = (PW+1)'(DEPTH/2);
  localparam logic [DCW-1:0] DROP_MAX = '1;

  logic [AW-1:0] mem_pc   [DEPTH];
  logic [AW-1:0] mem_addr [DEPTH];
  logic [DW-1:0] mem_data [DEPTH];
  logic          mem_we   [DEPTH];

  logic [PW-1:0] wptr, rptr;
  logic [PW:0]   cnt, pend;
  logic [AW-1:0] mask, match;
  logic [DCW-1:0] drops;

  wire hit     = wb_cyc & wb_stb & wb_ack;
  wire is_text = wb_we && (wb_adr == TEXT_ADDR);
  wire keep    = hit && (is_text || ((wb_adr & mask) == (match & mask)));
  wire full    = (cnt == FULL_LVL);
  wire push    = keep && !full;
  wire drop    = keep && full;
  wire pop     = rd_en && (cnt != '0);
  wire start   = !flush_req && (cnt > HALF_LVL);

  assign rd_valid = (cnt != '0);
  assign rd_pc    = mem_pc[rptr];
  assign rd_addr  = mem_addr[rptr];
  assign rd_data  = mem_data[rptr];
  assign rd_we    = mem_we[rptr];
  assign fill     = cnt;

  always_ff @(posedge clk) begin
    if (push) begin
      mem_pc[wptr]   <= pc_in;
      mem_addr[wptr] <= wb_adr;
      mem_data[wptr] <= wb_we ? wb_dat_w : wb_dat_r;
      mem_we[wptr]   <= wb_we;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      mask <= '0;
      match <= '0;
    end else begin
      if (cfg_wr) begin
        mask  <= cfg_mask;
        match <= cfg_match;
      end
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      cnt <= cnt + {{PW{1'b0}}, push} - {{PW{1'b0}}, pop};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_req <= 1'b0;
      pend      <= '0;
      drops     <= '0;
      hdr_drops <= '0;
    end else if (start) begin
      flush_req <= 1'b1;
      pend      <= cnt;
      hdr_drops <= drops;
      drops     <= {{(DCW-1){1'b0}}, drop};
    end else begin
      if (drop && drops != DROP_MAX) drops <= drops + 1'b1;
      if (flush_req && pop) begin
        pend <= pend - 1'b1;
        if (pend == {{PW{1'b0}}, 1'b1}) flush_req <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bus_trace_logger_chk.sv
module bus_trace_logger_chk #(
  parameter int DEPTH = 64
) (
  input logic clk,
  input logic rst_n,
  input logic wb_cyc,
  input logic wb_stb,
  input logic wb_ack,
  input logic rd_en,
  input logic [$clog2(DEPTH):0] fill,
  input logic flush_req
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] FULL_LVL = (PW+1)'(DEPTH);
  localparam logic [PW:0] HALF_LVL = (PW+1)'(DEPTH/2);

  wire cap = wb_cyc & wb_stb & wb_ack;

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_LVL);

  assert_flush_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_req) |-> $past(fill) > HALF_LVL);

  assert_flush_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_req) |-> $past(rd_en));

  assert_fill_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap && !rd_en) |=> $stable(fill));

  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap && rd_en && fill == '0) |=> fill == '0);
endmodule

bind bus_trace_logger bus_trace_logger_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
  .wb_ack(wb_ack), .rd_en(rd_en), .fill(fill), .flush_req(flush_req)
);

// File: tb/sim_bus_trace_logger.sv
`timescale 1ns/1ps
module sim_bus_trace_logger;
  logic clk = 0, rst_n = 0;
  logic wb_cyc = 0, wb_stb = 0, wb_ack = 0, wb_we = 0;
  logic [31:0] wb_adr = 0, wb_dat_w = 0, wb_dat_r = 0, pc_in = 0;
  logic cfg_wr = 0;
  logic [31:0] cfg_mask = 0, cfg_match = 0;
  logic rd_en = 0;
  logic rd_valid, rd_we, flush_req;
  logic [31:0] rd_pc, rd_addr, rd_data;
  logic [6:0] fill;
  logic [7:0] hdr_drops;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  bus_trace_logger u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [31:0] adr, input logic [31:0] dw,
                      input logic [31:0] dr, input logic [31:0] pc,
                      input logic cyc = 1, input logic ack = 1);
    @(negedge clk);
    wb_cyc = cyc; wb_stb = 1; wb_ack = ack; wb_we = we;
    wb_adr = adr; wb_dat_w = dw; wb_dat_r = dr; pc_in = pc;
    @(negedge clk);
    wb_cyc = 0; wb_stb = 0; wb_ack = 0;
  endtask

  task automatic pop_chk(input string req, input logic [31:0] pc, input logic [31:0] adr,
                         input logic [31:0] dat, input logic we);
    chk(req, {31'b0, rd_valid}, 32'd1);
    chk(req, rd_pc, pc);
    chk(req, rd_addr, adr);
    chk(req, rd_data, dat);
    chk(req, {31'b0, rd_we}, {31'b0, we});
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic set_cfg(input logic [31:0] m, input logic [31:0] v);
    @(negedge clk);
    cfg_mask = m; cfg_match = v; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic t_reset();
    chk("R9 fill", {25'b0, fill}, 0);
    chk("R9 valid", {31'b0, rd_valid}, 0);
    chk("R9 flush", {31'b0, flush_req}, 0);
    chk("R9 drops", {24'b0, hdr_drops}, 0);
  endtask

  task automatic t_capture();
    xfer(1, 32'h100, 32'hAAAA, 32'hBBBB, 32'h10, 1, 0);
    xfer(1, 32'h104, 32'hCCCC, 32'hDDDD, 32'h14, 0, 1);
    chk("R1 partial handshake", {25'b0, fill}, 0);
    xfer(1, 32'h200, 32'h1111, 32'h2222, 32'h20);
    xfer(0, 32'h204, 32'h3333, 32'h4444, 32'h24);
    chk("R4 fill", {25'b0, fill}, 2);
    pop_chk("R1 write rec", 32'h20, 32'h200, 32'h1111, 1);
    pop_chk("R1 read rec R4", 32'h24, 32'h204, 32'h4444, 0);
    chk("R4 empty", {31'b0, rd_valid}, 0);
  endtask

  task automatic t_empty_pop();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    chk("R8 fill", {25'b0, fill}, 0);
    xfer(1, 32'h300, 32'h5555, 0, 32'h30);
    chk("R8 fill after push", {25'b0, fill}, 1);
    pop_chk("R8 head", 32'h30, 32'h300, 32'h5555, 1);
  endtask

  task automatic t_mask();
    set_cfg(32'hFFFF_0000, 32'h1234_0000);
    xfer(1, 32'h1234_5678, 32'h1, 0, 32'h40);
    xfer(1, 32'h9999_0000, 32'h2, 0, 32'h44);
    xfer(1, 32'hFFFF_FFFC, 32'h48, 0, 32'h48);
    xfer(0, 32'hFFFF_FFFC, 0, 32'h3, 32'h4C);
    xfer(0, 32'h1234_ABCD, 0, 32'h77, 32'h50);
    chk("R2 R3 kept count", {25'b0, fill}, 3);
    pop_chk("R2 match", 32'h40, 32'h1234_5678, 32'h1, 1);
    pop_chk("R3 text write", 32'h48, 32'hFFFF_FFFC, 32'h48, 1);
    pop_chk("R2 read match", 32'h50, 32'h1234_ABCD, 32'h77, 0);
    set_cfg(0, 0);
  endtask

  task automatic t_flush();
    for (int i = 0; i < 33; i++) xfer(1, 32'h800 + i, i, 0, 32'd200 + i);
    chk("R5 not yet", {31'b0, flush_req}, 0);
    @(negedge clk);
    chk("R5 rise", {31'b0, flush_req}, 1);
    xfer(1, 32'h900, 32'h99, 0, 32'd300);
    xfer(1, 32'h904, 32'h9A, 0, 32'd301);
    for (int i = 0; i < 32; i++) pop_chk("R6 drain", 32'd200 + i, 32'h800 + i, i, 1);
    chk("R6 held", {31'b0, flush_req}, 1);
    pop_chk("R6 drain", 32'd232, 32'h820, 32'd32, 1);
    chk("R6 fall", {31'b0, flush_req}, 0);
    chk("R6 left", {25'b0, fill}, 2);
    pop_chk("R6 late", 32'd300, 32'h900, 32'h99, 1);
    pop_chk("R6 late", 32'd301, 32'h904, 32'h9A, 1);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 64; i++) xfer(1, 32'hA00 + i, i, 0, i);
    for (int i = 0; i < 3; i++) xfer(1, 32'hB00 + i, 0, 0, 32'd500 + i);
    chk("R7 full", {25'b0, fill}, 64);
    chk("R7 hdr before", {24'b0, hdr_drops}, 0);
    for (int i = 0; i < 33; i++) pop_chk("R7 order", i, 32'hA00 + i, i, 1);
    chk("R7 flush done", {31'b0, flush_req}, 0);
    xfer(1, 32'hC00, 32'h1, 0, 32'd100);
    xfer(1, 32'hC04, 32'h2, 0, 32'd101);
    @(negedge clk);
    chk("R7 new flush", {31'b0, flush_req}, 1);
    chk("R7 hdr drops", {24'b0, hdr_drops}, 3);
    for (int i = 33; i < 64; i++) pop_chk("R7 no lost rec", i, 32'hA00 + i, i, 1);
    pop_chk("R7 after drop", 32'd100, 32'hC00, 32'h1, 1);
    pop_chk("R7 after drop", 32'd101, 32'hC04, 32'h2, 1);
    chk("R7 empty", {25'b0, fill}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_capture();
    t_empty_pop();
    t_mask();
    t_flush();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule